// File: doc/BRIEF.md
# Trap-State Return Unit

This block performs the register-restoring half of a return from a trap handler. When the pipeline issues a return request, it also supplies the trap-stack entry for the current trap level. That entry holds a packed 64-bit state word, the saved program counter and the saved next program counter. The unit takes the state word apart and restores the condition-code byte, the address-space identifier, the processor-state value (with the reserved bits cleared) and the current window pointer. It converts that pointer from the reversed numbering held in the word to the internal numbering. It then produces the new PC pair and the decremented trap level.

Two return flavours share the same unpacking path. The "done" flavour resumes after the trapped instruction. The "retry" flavour re-executes the trapped instruction. A request made while the trap level is already zero is refused: an illegal-instruction strobe is raised and every restored output keeps its previous value.

Control is a three-state machine. IDLE is the state with no result pending. RESULT presents the restored fields with the valid strobe. FAULT presents the illegal-instruction strobe. Each state moves on every clock as follows:
- to RESULT on a request with a nonzero trap level (transition ACCEPT);
- to FAULT on a request with a zero trap level (transition REFUSE);
- to IDLE when there is no request (transition QUIET).

Back-to-back requests are therefore served one per cycle.

Top module: `trs_return_unit`

## Requirements
- R1: After reset, `ret_valid` and `ret_illegal` are 0 and every restored output (`ret_ccr`, `ret_asi`, `ret_pstate`, `ret_cwp`, `ret_pc`, `ret_npc`, `ret_tl`) is 0.
- R2: `ret_ccr` equals state-word bits 39:32. Bits 7:4 are the 64-bit flags and bits 3:0 are the 32-bit flags.
- R3: `ret_asi` equals state-word bits 31:24.
- R4: `ret_pstate` equals state-word bits 19:8 ANDed with 12'hF3F, so result bits 7:6 are always 0.
- R5: `ret_cwp` equals NWIN-1-(bits 7:0 mod NWIN). Bits 7:0 of the state word hold the reversed window number.
- R6: For a "done" request (`req_kind`=0), `ret_pc` is the saved next-PC and `ret_npc` is the saved next-PC plus 4, modulo 2^PCW.
- R7: For a "retry" request (`req_kind`=1), `ret_pc` is the saved PC and `ret_npc` is the saved next-PC.
- R8: `ret_tl` equals the requesting trap level minus one.
- R9: A request with `cur_tl`=0 raises `ret_illegal` for exactly one cycle on the next clock, leaves `ret_valid` low, and leaves every restored output unchanged.
- R10: Every request with a nonzero trap level yields a `ret_valid` pulse on the next clock that lasts one cycle, unless another accepted request follows at once. Back-to-back requests yield one valid cycle each, carrying each request's own results.
- R11: `ret_valid` and `ret_illegal` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Return request, one cycle per request |
| req_kind | input | 1 | 0 = done, 1 = retry |
| saved_state | input | 64 | Packed trap-state word of the current level |
| saved_pc | input | PCW | Saved PC of the current level |
| saved_npc | input | PCW | Saved next-PC of the current level |
| cur_tl | input | TLW | Current trap level |
| ret_valid | output | 1 | One-cycle strobe: restored fields are new |
| ret_illegal | output | 1 | One-cycle strobe: request refused at trap level 0 |
| ret_ccr | output | 8 | Restored condition codes |
| ret_asi | output | 8 | Restored address-space identifier |
| ret_pstate | output | 12 | Restored, masked processor state |
| ret_cwp | output | CWPW | Restored window pointer, internal numbering |
| ret_pc | output | PCW | New PC |
| ret_npc | output | PCW | New next-PC |
| ret_tl | output | TLW | Decremented trap level |

## Verification
The bench builds the unit with NWIN=6, PCW=32 and TLW=3. Six is not a power of two, so raw window values at and above six drive the true remainder path rather than a bit slice. That includes 255, which reduces to 3. A 32-bit PC makes the "done" next-PC wrap past all-ones easy to reach. A 3-bit trap level lets the top level 7 and the refused level 0 both be exercised.

// File: rtl/trs_pkg.sv
package trs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RESULT = 2'd1,
        ST_FAULT  = 2'd2
    } trs_state_e;

    typedef enum logic {
        KIND_DONE  = 1'b0,
        KIND_RETRY = 1'b1
    } trs_kind_e;

    localparam logic [11:0] PSTATE_KEEP = 12'hF3F;

    typedef struct packed {
        logic [7:0]  ccr;
        logic [7:0]  asi;
        logic [11:0] pstate;
        logic [7:0]  cwp_raw;
    } trs_fields_t;

endpackage

// File: rtl/trs_fsm.sv
module trs_fsm
    import trs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic tl_zero,
    output logic load_en,
    output logic valid_q,
    output logic illegal_q
);

    trs_state_e state_q, state_d;

    // next-state choice: ACCEPT, REFUSE or QUIET from any state
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_RESULT, ST_FAULT: begin
                if (req_valid && !tl_zero)
                    state_d = ST_RESULT;
                else if (req_valid)
                    state_d = ST_FAULT;
                else
                    state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // outputs decoded from the state
    always_comb begin
        valid_q   = 1'b0;
        illegal_q = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_RESULT: valid_q   = 1'b1;
            ST_FAULT:  illegal_q = 1'b1;
            default:   ;
        endcase
    end

    assign load_en = req_valid && !tl_zero;

    assert_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_q && illegal_q));

    assert_fault_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && tl_zero) |=> (illegal_q && !valid_q));

endmodule

// File: rtl/trs_unpack.sv
module trs_unpack
    import trs_pkg::*;
#(
    parameter int NWIN = 8,
    localparam int CWPW = $clog2(NWIN)
) (
    input  logic [63:0]     state_word,
    output trs_fields_t     fields,
    output logic [CWPW-1:0] cwp_int
);

    logic [CWPW-1:0] wrapped;
    logic            unused_hi;

    assign fields.ccr     = state_word[39:32];
    assign fields.asi     = state_word[31:24];
    assign fields.pstate  = state_word[19:8] & PSTATE_KEEP;
    assign fields.cwp_raw = state_word[7:0];
    assign unused_hi      = ^{state_word[63:40], state_word[23:20]};

    generate
        if ((NWIN & (NWIN - 1)) == 0) begin : g_pow2
            logic unused_top;
            assign wrapped    = fields.cwp_raw[CWPW-1:0];
            assign unused_top = ^fields.cwp_raw;
        end else begin : g_mod
            logic [7:0] rem;
            logic       unused_rem;
            assign rem        = fields.cwp_raw % 8'(NWIN);
            assign wrapped    = rem[CWPW-1:0];
            assign unused_rem = ^rem;
        end
    endgenerate

    // reversed numbering to internal numbering
    assign cwp_int = CWPW'(NWIN - 1) - wrapped;

endmodule

// File: rtl/trs_pc_sel.sv
module trs_pc_sel
    import trs_pkg::*;
#(
    parameter int PCW = 64
) (
    input  trs_kind_e        kind,
    input  logic [PCW-1:0]   pc_in,
    input  logic [PCW-1:0]   npc_in,
    output logic [PCW-1:0]   pc_out,
    output logic [PCW-1:0]   npc_out
);

    localparam logic [PCW-1:0] STEP = PCW'(4);

    always_comb begin
        unique case (kind)
            KIND_DONE: begin
                pc_out  = npc_in;
                npc_out = npc_in + STEP;
            end
            KIND_RETRY: begin
                pc_out  = pc_in;
                npc_out = npc_in;
            end
            default: begin
                pc_out  = pc_in;
                npc_out = npc_in;
            end
        endcase
    end

endmodule

// File: rtl/trs_return_unit.sv
module trs_return_unit
    import trs_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int PCW  = 64,
    parameter int TLW  = 3,
    localparam int CWPW = $clog2(NWIN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic            req_kind,
    input  logic [63:0]     saved_state,
    input  logic [PCW-1:0]  saved_pc,
    input  logic [PCW-1:0]  saved_npc,
    input  logic [TLW-1:0]  cur_tl,
    output logic            ret_valid,
    output logic            ret_illegal,
    output logic [7:0]      ret_ccr,
    output logic [7:0]      ret_asi,
    output logic [11:0]     ret_pstate,
    output logic [CWPW-1:0] ret_cwp,
    output logic [PCW-1:0]  ret_pc,
    output logic [PCW-1:0]  ret_npc,
    output logic [TLW-1:0]  ret_tl
);

    logic            tl_zero;
    logic            load_en;
    trs_fields_t     fields;
    logic [CWPW-1:0] cwp_int;
    logic [PCW-1:0]  pc_next, npc_next;

    assign tl_zero = (cur_tl == '0);

    trs_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .tl_zero   (tl_zero),
        .load_en   (load_en),
        .valid_q   (ret_valid),
        .illegal_q (ret_illegal)
    );

    trs_unpack #(.NWIN(NWIN)) u_unpack (
        .state_word (saved_state),
        .fields     (fields),
        .cwp_int    (cwp_int)
    );

    trs_pc_sel #(.PCW(PCW)) u_pc_sel (
        .kind    (trs_kind_e'(req_kind)),
        .pc_in   (saved_pc),
        .npc_in  (saved_npc),
        .pc_out  (pc_next),
        .npc_out (npc_next)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ret_ccr    <= '0;
            ret_asi    <= '0;
            ret_pstate <= '0;
            ret_cwp    <= '0;
            ret_pc     <= '0;
            ret_npc    <= '0;
            ret_tl     <= '0;
        end else if (load_en) begin
            ret_ccr    <= fields.ccr;
            ret_asi    <= fields.asi;
            ret_pstate <= fields.pstate;
            ret_cwp    <= cwp_int;
            ret_pc     <= pc_next;
            ret_npc    <= npc_next;
            ret_tl     <= cur_tl - TLW'(1);
        end
    end

    assert_valid_next_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cur_tl != '0) |=> ret_valid);

    assert_tl_dec_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cur_tl != '0) |=> (ret_tl == $past(cur_tl) - TLW'(1)));

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cur_tl == '0) |=> ($stable(ret_pc) && $stable(ret_npc) && $stable(ret_tl)));

    assert_pstate_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |-> (ret_pstate[7:6] == 2'b00));

    assert_cwp_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |-> (int'(ret_cwp) < NWIN));

    assert_retry_pc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cur_tl != '0 && req_kind) |=> (ret_pc == $past(saved_pc)));

endmodule

// File: tb/tb_trs_return_unit.sv
module tb_trs_return_unit;

    localparam int CLK_PERIOD = 10;
    localparam int NWIN = 6;
    localparam int PCW  = 32;
    localparam int TLW  = 3;
    localparam int CWPW = $clog2(NWIN);

    logic            clk = 1'b0;
    logic            rst_n;
    logic            req_valid;
    logic            req_kind;
    logic [63:0]     saved_state;
    logic [PCW-1:0]  saved_pc, saved_npc;
    logic [TLW-1:0]  cur_tl;
    logic            ret_valid, ret_illegal;
    logic [7:0]      ret_ccr, ret_asi;
    logic [11:0]     ret_pstate;
    logic [CWPW-1:0] ret_cwp;
    logic [PCW-1:0]  ret_pc, ret_npc;
    logic [TLW-1:0]  ret_tl;

    int total = 0;
    int bad   = 0;
    bit ended = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trs_return_unit #(.NWIN(NWIN), .PCW(PCW), .TLW(TLW)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .saved_state(saved_state), .saved_pc(saved_pc), .saved_npc(saved_npc),
        .cur_tl(cur_tl), .ret_valid(ret_valid), .ret_illegal(ret_illegal),
        .ret_ccr(ret_ccr), .ret_asi(ret_asi), .ret_pstate(ret_pstate),
        .ret_cwp(ret_cwp), .ret_pc(ret_pc), .ret_npc(ret_npc), .ret_tl(ret_tl)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] make_state(input logic [7:0] ccr, input logic [7:0] asi,
                                               input logic [11:0] ps, input logic [7:0] cwp);
        return {24'hA5A5A5, ccr, asi, 4'hF, ps, cwp};
    endfunction

    function automatic int exp_cwp(input int raw);
        return NWIN - 1 - (raw % NWIN);
    endfunction

    // drive one request at a falling edge; results are visible one edge later
    task automatic issue(input logic kind, input logic [63:0] st,
                         input logic [PCW-1:0] pc, input logic [PCW-1:0] npc,
                         input logic [TLW-1:0] tl);
        req_valid   = 1'b1;
        req_kind    = kind;
        saved_state = st;
        saved_pc    = pc;
        saved_npc   = npc;
        cur_tl      = tl;
        @(negedge clk);
        req_valid   = 1'b0;
    endtask

    task automatic t_reset;
        check("R1", "valid", 64'(ret_valid), 64'd0);
        check("R1", "illegal", 64'(ret_illegal), 64'd0);
        check("R1", "ccr", 64'(ret_ccr), 64'd0);
        check("R1", "pc/npc", {ret_pc, ret_npc}, 64'd0);
        check("R1", "cwp/tl/asi/pstate", 64'({ret_cwp, ret_tl, ret_asi, ret_pstate}), 64'd0);
    endtask

    task automatic t_done;
        issue(1'b0, make_state(8'h9C, 8'h80, 12'h0A5, 8'd0), 32'h1000, 32'h1004, 3'd2);
        check("R10", "valid", 64'(ret_valid), 64'd1);
        check("R2", "ccr", 64'(ret_ccr), 64'h9C);
        check("R3", "asi", 64'(ret_asi), 64'h80);
        check("R4", "pstate", 64'(ret_pstate), 64'h025);
        check("R5", "cwp raw0", 64'(ret_cwp), 64'(exp_cwp(0)));
        check("R6", "pc", 64'(ret_pc), 64'h1004);
        check("R6", "npc", 64'(ret_npc), 64'h1008);
        check("R8", "tl", 64'(ret_tl), 64'd1);
        @(negedge clk);
        check("R10", "valid drops", 64'(ret_valid), 64'd0);
    endtask

    task automatic t_retry;
        issue(1'b1, make_state(8'h3F, 8'h04, 12'hFFF, 8'd13), 32'h2000, 32'h2004, 3'd7);
        check("R10", "valid", 64'(ret_valid), 64'd1);
        check("R7", "pc", 64'(ret_pc), 64'h2000);
        check("R7", "npc", 64'(ret_npc), 64'h2004);
        check("R4", "pstate mask", 64'(ret_pstate), 64'hF3F);
        check("R5", "cwp raw13", 64'(ret_cwp), 64'(exp_cwp(13)));
        check("R8", "tl top", 64'(ret_tl), 64'd6);
        @(negedge clk);
    endtask

    task automatic t_cwp_edges;
        issue(1'b1, make_state(8'h00, 8'h00, 12'h000, 8'd255), 32'h0, 32'h4, 3'd1);
        check("R5", "cwp raw255", 64'(ret_cwp), 64'(exp_cwp(255)));
        check("R8", "tl to zero", 64'(ret_tl), 64'd0);
        @(negedge clk);
        issue(1'b1, make_state(8'h00, 8'h00, 12'h000, 8'd5), 32'h0, 32'h4, 3'd1);
        check("R5", "cwp raw5", 64'(ret_cwp), 64'(exp_cwp(5)));
        @(negedge clk);
    endtask

    task automatic t_npc_wrap;
        issue(1'b0, make_state(8'h00, 8'h00, 12'h000, 8'd6), 32'h0, 32'hFFFF_FFFC, 3'd3);
        check("R6", "pc wrap", 64'(ret_pc), 64'hFFFF_FFFC);
        check("R6", "npc wrap", 64'(ret_npc), 64'h0);
        check("R5", "cwp raw6", 64'(ret_cwp), 64'(exp_cwp(6)));
        @(negedge clk);
    endtask

    task automatic t_refuse;
        issue(1'b0, make_state(8'h11, 8'h22, 12'h333, 8'd2), 32'h5000, 32'h5004, 3'd0);
        check("R9", "illegal", 64'(ret_illegal), 64'd1);
        check("R9", "no valid", 64'(ret_valid), 64'd0);
        check("R9", "pc held", 64'(ret_pc), 64'hFFFF_FFFC);
        check("R9", "ccr held", 64'(ret_ccr), 64'h00);
        check("R9", "tl held", 64'(ret_tl), 64'd2);
        @(negedge clk);
        check("R9", "illegal drops", 64'(ret_illegal), 64'd0);
        check("R11", "no overlap", 64'(ret_valid & ret_illegal), 64'd0);
    endtask

    task automatic t_back_to_back;
        issue(1'b1, make_state(8'hA1, 8'h01, 12'h001, 8'd1), 32'h100, 32'h104, 3'd4);
        check("R10", "b2b valid 1", 64'(ret_valid), 64'd1);
        check("R7", "b2b pc 1", 64'(ret_pc), 64'h100);
        issue(1'b0, make_state(8'hB2, 8'h02, 12'h002, 8'd2), 32'h200, 32'h204, 3'd3);
        check("R10", "b2b valid 2", 64'(ret_valid), 64'd1);
        check("R6", "b2b pc 2", 64'(ret_pc), 64'h204);
        check("R2", "b2b ccr 2", 64'(ret_ccr), 64'hB2);
        check("R8", "b2b tl 2", 64'(ret_tl), 64'd2);
        @(negedge clk);
        check("R10", "b2b valid ends", 64'(ret_valid), 64'd0);
    endtask

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_kind = 1'b0;
        saved_state = '0; saved_pc = '0; saved_npc = '0; cur_tl = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_done();
        t_retry();
        t_cwp_edges();
        t_npc_wrap();
        t_refuse();
        t_back_to_back();
        if (!ended) begin
            ended = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule